// File: doc/BRIEF.md
# OLED Panel Power Sequencer

This block brings a small monochrome OLED panel up and down in a fixed order. On a start-up request it turns on the logic supply and waits until that supply reports stable. It then holds the panel reset line low for a timed interval and releases it together with the high-voltage enable. Once the high-voltage supply reports stable, it sends the display-on byte to a command transmitter and waits for a settle interval. After that it signals ready.

On a shutdown request it sends the display-off byte, drops the high-voltage enable and waits a settle interval. It then drops the logic supply. A shutdown that arrives mid-way through start-up is remembered and carried out as soon as start-up finishes.

Each command byte leaves through a request/acknowledge pair, and the byte counts as sent on the cycle the transmitter acknowledges it. The reset interval and the settle interval are given in nanoseconds and microseconds. They are converted to clock cycles from a clock-frequency parameter, rounding up.

Top module: `oled_pwr_seq`

## Requirements
- R1: After reset the block is idle. A start_req pulse seen in idle raises vdd_en and busy on the next cycle. panel_rst_n stays low until vdd_ok has been seen high.
- R2: After vdd_ok is sampled high, panel_rst_n stays low for exactly RST_CYC more cycles. RST_CYC is ceil(CLK_HZ*RESET_NS/1e9), and at least 1. panel_rst_n and vcc_en then rise together. vcc_en is never high without vdd_en.
- R3: Once vcc_ok is sampled high, cmd_valid rises with cmd_byte = 0xAF. Both are held until cmd_ack is sampled high while cmd_valid is high. cmd_byte reads 0x00 whenever cmd_valid is low.
- R4: After the 0xAF byte is acknowledged, ready rises exactly SET_CYC+1 cycles later and busy falls with it. SET_CYC is ceil(CLK_HZ*SETTLE_US/1e6), and at least 1.
- R5: A stop_req while ready drops ready, raises busy and raises cmd_valid with cmd_byte = 0xAE until it is acknowledged. vcc_en falls on the cycle after that acknowledge.
- R6: vdd_en falls exactly SET_CYC cycles after vcc_en falls. At the same time panel_rst_n goes low and busy goes low, and the block is idle again.
- R7: A stop_req seen at any point between the start request and the end of the power-up settle interval is kept pending. At the end of that interval the block goes straight to the 0xAE step and ready never rises.
- R8: start_req has no effect outside idle. stop_req has no effect in idle and during power-down.
- R9: busy is high in every step except idle and ready. ready and busy are never high together.
- R10: While cmd_valid is high and not yet acknowledged, cmd_byte does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to power the panel up |
| stop_req | input | 1 | Request to power the panel down |
| vdd_ok | input | 1 | Logic supply is stable (synchronous to clk) |
| vcc_ok | input | 1 | High-voltage supply is stable (synchronous to clk) |
| cmd_ack | input | 1 | Transmitter has taken the command byte |
| panel_rst_n | output | 1 | Panel reset line, active low |
| vdd_en | output | 1 | Logic supply enable |
| vcc_en | output | 1 | High-voltage supply enable |
| cmd_valid | output | 1 | Command byte request |
| cmd_byte | output | 8 | Command byte: 0xAF display-on, 0xAE display-off |
| busy | output | 1 | A sequence step is in progress |
| ready | output | 1 | Panel is powered and on |

## Verification
Every output is a decode of the sequencer step. A wrong internal step therefore shows on the enables, on the reset line or on the command pair in the very next cycle, and the per-cycle comparison catches it there. A timer that is wrong by one count shows only at the end of an interval. That means 5 cycles after vdd_ok for the reset pulse, and SET_CYC cycles after the acknowledge or after the high-voltage drop for the settle waits, so those edges are timed exactly. A lost pending shutdown shows as ready rising when it should not, at the end of power-up.

// File: rtl/oled_pwr_pkg.sv
package oled_pwr_pkg;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_VDD     = 4'd1,
        S_RST     = 4'd2,
        S_VCC     = 4'd3,
        S_CMD_ON  = 4'd4,
        S_SET_ON  = 4'd5,
        S_READY   = 4'd6,
        S_CMD_OFF = 4'd7,
        S_SET_OFF = 4'd8
    } seq_state_t;

    localparam logic [7:0] BYTE_DISP_ON  = 8'hAF;
    localparam logic [7:0] BYTE_DISP_OFF = 8'hAE;

    // cycles = ceil(hz * amount / units_per_second), never below one
    function automatic longint unsigned to_cycles(longint unsigned hz,
                                                  longint unsigned amount,
                                                  longint unsigned units_per_s);
        longint unsigned c;
        c = (hz * amount + units_per_s - 1) / units_per_s;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/oled_seq_timer.sv
module oled_seq_timer #(
    parameter int unsigned SHORT_CYC = 4,
    parameter int unsigned LONG_CYC  = 16,
    parameter int unsigned W         = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_long,
    output logic done
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;
    logic [W-1:0] limit;

    always_comb begin
        limit = sel_long ? W'(LONG_CYC - 1) : W'(SHORT_CYC - 1);
        done  = run && (q.cnt == limit);
        d     = q;
        if (!run || done) d.cnt = '0;
        else              d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2 / R4: the count never runs past the selected interval
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt <= limit));

    // R4: an idle timer restarts from zero
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q.cnt == '0));
endmodule

// File: rtl/oled_seq_cmd.sv
module oled_seq_cmd
    import oled_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want_on,
    input  logic       want_off,
    input  logic       cmd_ack,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte,
    output logic       sent
);
    always_comb begin
        cmd_valid = want_on || want_off;
        cmd_byte  = want_on ? BYTE_DISP_ON : (want_off ? BYTE_DISP_OFF : 8'h00);
        sent      = cmd_valid && cmd_ack;
    end

    // R10: an unacknowledged byte is held
    a_r10_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_byte)));

    // R3: both command requests never overlap
    a_r3_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(want_on && want_off));
endmodule

// File: rtl/oled_seq_req.sv
module oled_seq_req (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic powering_up,
    input  logic clear,
    output logic want_down
);
    typedef struct packed {
        logic pend;
    } req_t;

    req_t d, q;

    always_comb begin
        d = q;
        if (clear)                        d.pend = 1'b0;
        else if (stop_req && powering_up) d.pend = 1'b1;
        want_down = q.pend || stop_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: a pending shutdown survives until the off command step
    a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && !clear) |=> q.pend);
endmodule

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq
    import oled_pwr_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 50_000_000,
    parameter longint unsigned RESET_NS  = 3_000,
    parameter longint unsigned SETTLE_US = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       vdd_ok,
    input  logic       vcc_ok,
    input  logic       cmd_ack,
    output logic       panel_rst_n,
    output logic       vdd_en,
    output logic       vcc_en,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte,
    output logic       busy,
    output logic       ready
);
    localparam int unsigned RST_CYC = int'(to_cycles(CLK_HZ, RESET_NS, 64'd1_000_000_000));
    localparam int unsigned SET_CYC = int'(to_cycles(CLK_HZ, SETTLE_US, 64'd1_000_000));
    localparam int unsigned MAX_CYC = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
    localparam int unsigned TW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_t state;
    } seq_t;

    seq_t d, q;

    logic t_run, t_long, t_done;
    logic want_on, want_off, sent;
    logic powering_up, clear_pend, want_down;

    always_comb begin
        t_run       = (q.state == S_RST) || (q.state == S_SET_ON) || (q.state == S_SET_OFF);
        t_long      = (q.state != S_RST);
        want_on     = (q.state == S_CMD_ON);
        want_off    = (q.state == S_CMD_OFF);
        clear_pend  = (q.state == S_CMD_OFF);
        powering_up = (q.state == S_VDD) || (q.state == S_RST) || (q.state == S_VCC)
                   || (q.state == S_CMD_ON) || (q.state == S_SET_ON);
    end

    oled_seq_timer #(.SHORT_CYC(RST_CYC), .LONG_CYC(SET_CYC), .W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(t_run), .sel_long(t_long), .done(t_done)
    );

    oled_seq_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .want_on(want_on), .want_off(want_off),
        .cmd_ack(cmd_ack), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .sent(sent)
    );

    oled_seq_req u_req (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .powering_up(powering_up),
        .clear(clear_pend), .want_down(want_down)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            S_IDLE:    if (start_req) d.state = S_VDD;
            S_VDD:     if (vdd_ok)    d.state = S_RST;
            S_RST:     if (t_done)    d.state = S_VCC;
            S_VCC:     if (vcc_ok)    d.state = S_CMD_ON;
            S_CMD_ON:  if (sent)      d.state = S_SET_ON;
            S_SET_ON:  if (t_done)    d.state = want_down ? S_CMD_OFF : S_READY;
            S_READY:   if (want_down) d.state = S_CMD_OFF;
            S_CMD_OFF: if (sent)      d.state = S_SET_OFF;
            S_SET_OFF: if (t_done)    d.state = S_IDLE;
            default:                  d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: S_IDLE};
        else        q <= d;
    end

    always_comb begin
        vdd_en      = (q.state != S_IDLE);
        panel_rst_n = 1'b0;
        vcc_en      = 1'b0;
        case (q.state)
            S_VCC, S_CMD_ON, S_SET_ON, S_READY, S_CMD_OFF: begin
                panel_rst_n = 1'b1;
                vcc_en      = 1'b1;
            end
            S_SET_OFF: panel_rst_n = 1'b1;
            default: ;
        endcase
        ready = (q.state == S_READY);
        busy  = (q.state != S_IDLE) && (q.state != S_READY);
    end

    // R1: high-voltage enable only with the logic supply on
    a_r1_vcc_needs_vdd: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_en |-> vdd_en);

    // R2: reset was low just before the high-voltage enable rose
    a_r2_reset_before_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> $past(!panel_rst_n));

    // R3: display-on only with a stable high-voltage supply
    a_r3_on_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == BYTE_DISP_ON) |-> (vcc_en && vcc_ok));

    // R4: ready follows the end of the power-up settle interval
    a_r4_ready_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(q.state == S_SET_ON && t_done));

    // R5: high voltage drops only after the display-off byte is taken
    a_r5_vcc_drop_after_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_en) |-> $past(cmd_valid && cmd_ack && cmd_byte == BYTE_DISP_OFF));

    // R6: logic supply drops only after the power-down settle interval
    a_r6_vdd_drop_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vdd_en) |-> ($past(q.state == S_SET_OFF && t_done) && !vcc_en));

    // R9: ready and busy are exclusive
    a_r9_busy_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));
endmodule

// File: tb/oled_pwr_seq_test.sv
module oled_pwr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned HZ  = 1_500_000;
    localparam longint unsigned RNS = 3_000;
    localparam longint unsigned SUS = 1_000;
    // expected intervals from R2 / R4: ceil(1.5e6*3000/1e9)=5, ceil(1.5e6*1000/1e6)=1500
    localparam int RST_E = 5;
    localparam int SET_E = 1500;
    localparam int ACK_LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, stop_req = 1'b0;
    logic vdd_ok = 1'b0, vcc_ok = 1'b0, cmd_ack = 1'b0;
    logic panel_rst_n, vdd_en, vcc_en, cmd_valid, busy, ready;
    logic [7:0] cmd_byte;

    int n_vec = 0, n_bad = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oled_pwr_seq #(.CLK_HZ(HZ), .RESET_NS(RNS), .SETTLE_US(SUS)) uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .vdd_ok(vdd_ok), .vcc_ok(vcc_ok), .cmd_ack(cmd_ack),
        .panel_rst_n(panel_rst_n), .vdd_en(vdd_en), .vcc_en(vcc_en),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .busy(busy), .ready(ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // supply and transmitter responders, driven just after each edge
    int vdd_t = 0, vcc_t = 0, ack_t = 0;
    always @(posedge clk) begin
        #1;
        if (vdd_en) begin if (vdd_t < 3) vdd_t++; end else vdd_t = 0;
        vdd_ok = (vdd_t >= 3);
        if (vcc_en) begin if (vcc_t < 4) vcc_t++; end else vcc_t = 0;
        vcc_ok = (vcc_t >= 4);
        if (cmd_ack) cmd_ack = 1'b0;
        else if (cmd_valid) begin
            if (ack_t == ACK_LAT) begin cmd_ack = 1'b1; ack_t = 0; end
            else ack_t++;
        end else ack_t = 0;
    end

    // behavioural reference: phase number plus remaining-cycle counter
    int ph = 0, left = 0;
    bit pend = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin ph = 0; left = 0; pend = 0; end
        else begin
            automatic int old = ph;
            automatic bit downreq = pend || stop_req;
            case (old)
                0: if (start_req) ph = 1;
                1: if (vdd_ok) begin ph = 2; left = RST_E; end
                2: begin left--; if (left == 0) ph = 3; end
                3: if (vcc_ok) ph = 4;
                4: if (cmd_ack) begin ph = 5; left = SET_E; end
                5: begin left--; if (left == 0) ph = downreq ? 7 : 6; end
                6: if (downreq) ph = 7;
                7: if (cmd_ack) begin ph = 8; left = SET_E; end
                8: begin left--; if (left == 0) ph = 0; end
                default: ph = 0;
            endcase
            if (old == 7) pend = 0;
            else if (stop_req && old >= 1 && old <= 5) pend = 1;
        end
    end

    function automatic string tag_of(input int p);
        case (p)
            0: return "R1";
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R3";
            5: return "R4";
            6: return "R9";
            7: return "R5";
            default: return "R6";
        endcase
    endfunction

    // per-cycle comparison plus interval measurements
    bit pv_vdd_ok = 0, pv_vcc = 0, pv_vdd = 0, pv_ready = 0, ready_seen = 0;
    int t_vok = 0, t_ack_on = 0, t_ack_off = 0, t_vcc_fall = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            automatic bit  e_vdd = (ph != 0);
            automatic bit  e_rst = (ph >= 3);
            automatic bit  e_vcc = (ph >= 3 && ph <= 7);
            automatic bit  e_val = (ph == 4 || ph == 7);
            automatic int  e_byt = (ph == 4) ? 'hAF : ((ph == 7) ? 'hAE : 0);
            automatic bit  e_bsy = (ph != 0 && ph != 6);
            automatic bit  e_rdy = (ph == 6);
            automatic int  act = {panel_rst_n, vdd_en, vcc_en, cmd_valid, busy, ready};
            automatic int  exp = {e_rst, e_vdd, e_vcc, e_val, e_bsy, e_rdy};
            chk(act == exp, tag_of(ph), act, exp);
            chk(cmd_byte == e_byt[7:0], e_val ? tag_of(ph) : "R10", cmd_byte, e_byt);

            if (vdd_ok && !pv_vdd_ok && !vcc_en) t_vok = cyc;
            if (vcc_en && !pv_vcc) chk(cyc - t_vok == RST_E + 1, "R2 reset width", cyc - t_vok, RST_E + 1);
            if (cmd_valid && cmd_ack && cmd_byte == 8'hAF) t_ack_on = cyc;
            if (cmd_valid && cmd_ack && cmd_byte == 8'hAE) t_ack_off = cyc;
            if (ready && !pv_ready) begin
                ready_seen = 1;
                chk(cyc - t_ack_on == SET_E + 1, "R4 settle on", cyc - t_ack_on, SET_E + 1);
            end
            if (!vcc_en && pv_vcc) begin
                t_vcc_fall = cyc;
                chk(cyc - t_ack_off == 1, "R5 vcc drop", cyc - t_ack_off, 1);
            end
            if (!vdd_en && pv_vdd) chk(cyc - t_vcc_fall == SET_E, "R6 settle off", cyc - t_vcc_fall, SET_E);
        end
        pv_vdd_ok = vdd_ok; pv_vcc = vcc_en; pv_vdd = vdd_en; pv_ready = ready;
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic pulse_start();
        start_req = 1'b1; step(); start_req = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1; step(); stop_req = 1'b0;
    endtask

    task automatic wait_idle();
        step();
        while (vdd_en) step();
        step();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) step();
        @(negedge clk);
        chk({panel_rst_n, vdd_en, vcc_en, cmd_valid, busy, ready} == 0, "R9 reset state",
            {panel_rst_n, vdd_en, vcc_en, cmd_valid, busy, ready}, 0);
        step();
        rst_n = 1'b1;
        repeat (2) step();

        // R8: stop in idle has no effect
        pulse_stop();
        repeat (3) step();
        chk(vdd_en == 1'b0, "R8 stop in idle", vdd_en, 0);

        // normal power-up, with a stray start mid-way (R8)
        pulse_start();
        repeat (8) step();
        pulse_start();
        while (!ready) step();
        repeat (4) step();
        chk(ready == 1'b1, "R4 ready held", ready, 1);
        pulse_stop();
        repeat (4) step();
        pulse_start();                          // R8: ignored during power-down
        wait_idle();
        chk(vdd_en == 1'b0 && busy == 1'b0, "R6 idle again", {vdd_en, busy}, 0);

        // R7: stop early in power-up
        ready_seen = 0;
        pulse_start();
        step();
        pulse_stop();
        wait_idle();
        chk(ready_seen == 1'b0, "R7 early stop", ready_seen, 0);

        // R7: stop late, during the settle interval
        ready_seen = 0;
        pulse_start();
        while (!(vcc_en && !cmd_valid && vcc_ok && t_ack_on == cyc - 1)) step();
        repeat (100) step();
        pulse_stop();
        wait_idle();
        chk(ready_seen == 1'b0, "R7 late stop", ready_seen, 0);

        repeat (5) step();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
    end
endmodule